// File: doc/BRIEF.md
# Multi-channel interrupt multiplexer

This block takes 32 level-sensitive interrupt requests from a subsystem and folds them onto a few output interrupt lines, one line per channel. Every channel applies its own 32-bit enable mask to the same shared request bus. The channel drives its line while any request that it has enabled is active. The number of channels is a build-time parameter from 1 to 8.

Software reaches each channel through a group of four word registers on a simple single-cycle bus with a byte address. A channel's group starts at 0x40 times its index. Writes take effect at the clock edge where select and write are high. Read data is combinational and is valid in the same cycle as the request.

A handler reads the vector word to find the lowest-numbered active source. It can also read the pending word to see all active sources at once. It masks and unmasks sources with a read-modify-write of the enable word.

Top module: `irq_channel_mux`

## Requirements
- R1: A synchronous active-low reset clears every enable register to 0 and drives every channel output low. The output stays low after reset until an enable bit is written.
- R2: The enable register is at channel offset 0x10 and is read/write. Bit n set lets request n reach that channel. Bit n clear masks request n.
- R3: The pending register is at offset 0x20 and reads the bitwise AND of the live request levels and the channel's enable register. The read is combinational and not latched, so a bit clears as soon as its request drops.
- R4: A channel output is high exactly when that channel's pending value was nonzero at the previous clock edge, giving one cycle of latency.
- R5: The vector register is at offset 0x04 and returns the index of the lowest-numbered pending bit in bits 4:0, with all other bits zero. When nothing is pending it reads 0x8000_0000.
- R6: The control register is at offset 0x00. Bit 31 is read-only and equals the channel output. Writing 1 to bit 0 clears that channel's enable register. Bit 0 and all other bits read as 0.
- R7: Writes to the pending and vector offsets change no state.
- R8: Any offset other than 0x00, 0x04, 0x10 and 0x20 reads as zero and ignores writes. So does any channel index at or above the configured count, where the channel index is address bits 8:6.
- R9: Channels are independent. A write to one channel's registers leaves every other channel's enable and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 32 | Level-sensitive interrupt requests |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte address: bits 8:6 select the channel, bits 5:0 the register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is in progress |
| chan_irq | output | NUM_CH | One interrupt line per channel |

## Verification
The only state is each channel's enable mask and its registered output. A corrupted mask shows up at once, in the same cycle, in a read of the enable or pending word. It shows up one clock later as a wrong level on that channel's line. A stale output flop shows on the line and in control bit 31 for one cycle after each request change, so the bench samples both before and after the edge. Writes that should be ignored are checked by reading the enable word back and watching every channel line afterwards.

// File: rtl/irq_channel_mux.sv
module irq_channel_mux #(
  parameter int NUM_CH = 1,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_irq,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] chan_irq
);
  localparam int CHW = AW - 6;
  localparam logic [5:0] OFF_CSR = 6'h00;
  localparam logic [5:0] OFF_VEC = 6'h04;
  localparam logic [5:0] OFF_EN  = 6'h10;
  localparam logic [5:0] OFF_PND = 6'h20;

  logic [NUM_CH-1:0][31:0] en_q;
  logic [NUM_CH-1:0][31:0] rd_ch;
  logic [CHW-1:0] sel_ch;
  logic [5:0]     off;

  assign sel_ch = bus_addr[AW-1:6];
  assign off    = bus_addr[5:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [31:0] pend;
    logic [31:0] vec;
    logic        hit;

    assign pend = src_irq & en_q[c];
    assign hit  = bus_sel && bus_we && (int'(sel_ch) == c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[c]     <= '0;
        chan_irq[c] <= 1'b0;
      end else begin
        chan_irq[c] <= |pend;
        if (hit && off == OFF_EN) en_q[c] <= bus_wdata;
        else if (hit && off == OFF_CSR && bus_wdata[0]) en_q[c] <= '0;
      end
    end

    always_comb begin
      vec = 32'h8000_0000;
      for (int i = 31; i >= 0; i--)
        if (pend[i]) vec = 32'(i);
    end

    always_comb begin
      case (off)
        OFF_CSR: rd_ch[c] = {chan_irq[c], 31'b0};
        OFF_VEC: rd_ch[c] = vec;
        OFF_EN:  rd_ch[c] = en_q[c];
        OFF_PND: rd_ch[c] = pend;
        default: rd_ch[c] = '0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we)
      for (int c = 0; c < NUM_CH; c++)
        if (int'(sel_ch) == c) bus_rdata = rd_ch[c];
  end
endmodule

// File: rtl/irq_channel_mux_chk.sv
module irq_channel_mux_chk #(
  parameter int NUM_CH = 1,
  parameter int AW     = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [31:0]             src_irq,
  input logic                    bus_sel,
  input logic                    bus_we,
  input logic [AW-1:0]           bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_CH-1:0]       chan_irq,
  input logic [NUM_CH-1:0][31:0] en_q
);
  logic rd_pnd, rd_vec, rd_bad, wr_pnd;
  assign rd_pnd = bus_sel && !bus_we && bus_addr[5:0] == 6'h20;
  assign rd_vec = bus_sel && !bus_we && bus_addr[5:0] == 6'h04;
  assign rd_bad = bus_sel && !bus_we && !(bus_addr[5:0] inside {6'h00, 6'h04, 6'h10, 6'h20});
  assign wr_pnd = bus_sel && bus_we && (bus_addr[5:0] == 6'h20 || bus_addr[5:0] == 6'h04);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> chan_irq == '0);
  // R4
  no_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_irq) == 32'b0 |-> chan_irq == '0);
  // R3
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pnd |-> (bus_rdata & ~src_irq) == 32'b0);
  // R5
  vec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec && bus_rdata[31] |-> bus_rdata[30:0] == 31'b0);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> bus_rdata == 32'b0);
  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pnd |=> $stable(en_q));
endmodule

bind irq_channel_mux irq_channel_mux_chk #(.NUM_CH(NUM_CH), .AW(AW)) chk_i (.*);

// File: tb/irq_channel_mux_test.sv
`timescale 1ns/1ps
module irq_channel_mux_test;
  localparam int NCH = 2;
  logic clk = 0, rst_n = 0;
  logic [31:0] src_irq = 0, bus_wdata = 0, bus_rdata;
  logic bus_sel = 0, bus_we = 0;
  logic [8:0] bus_addr = 0;
  logic [NCH-1:0] chan_irq;
  int total = 0, bad = 0;
  bit done = 0;

  irq_channel_mux #(.NUM_CH(NCH), .AW(9)) uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic drive(logic [31:0] s);
    @(negedge clk); src_irq = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs", 32'(chan_irq), 0);
    rd(9'h010, d); chk("R1 en ch0", d, 0);
    rd(9'h050, d); chk("R1 en ch1", d, 0);
    drive(32'hFFFF_FFFF);
    chk("R1 masked out", 32'(chan_irq), 0);
    drive(0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(9'h010, 32'h0000_00F0);
    rd(9'h010, d); chk("R2 en readback", d, 32'h0000_00F0);
    @(negedge clk); src_irq = 32'h0000_0330;
    #1 chk("R4 no change before edge", 32'(chan_irq), 0);
    @(negedge clk);
    chk("R4 ch0 up", 32'(chan_irq), 32'b01);
    rd(9'h020, d); chk("R3 pend", d, 32'h0000_0030);
    rd(9'h004, d); chk("R5 vector", d, 4);
    rd(9'h000, d); chk("R6 csr mirror", d, 32'h8000_0000);
    rd(9'h060, d); chk("R9 ch1 pend", d, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); src_irq = 0;
    #1 chk("R4 still high before edge", 32'(chan_irq), 32'b01);
    rd(9'h020, d); chk("R3 not latched", d, 0);
    chk("R4 ch0 down", 32'(chan_irq), 0);
    rd(9'h004, d); chk("R5 vector empty", d, 32'h8000_0000);
    rd(9'h000, d); chk("R6 csr low", d, 0);
  endtask

  task automatic t_vector;
    logic [31:0] d;
    wr(9'h010, 32'hFFFF_FFFF);
    drive(32'h8000_0000);
    rd(9'h004, d); chk("R5 vector 31", d, 31);
    drive(32'h8000_0001);
    rd(9'h004, d); chk("R5 vector 0", d, 0);
    drive(32'h0001_0400);
    rd(9'h004, d); chk("R5 vector 10", d, 10);
  endtask

  task automatic t_indep;
    logic [31:0] d;
    wr(9'h010, 32'h0000_0002);
    wr(9'h050, 32'h0000_0001);
    drive(32'h0000_0001);
    chk("R9 only ch1", 32'(chan_irq), 32'b10);
    rd(9'h020, d); chk("R9 ch0 pend", d, 0);
    rd(9'h060, d); chk("R9 ch1 pend", d, 1);
    rd(9'h040, d); chk("R9 ch1 csr", d, 32'h8000_0000);
  endtask

  task automatic t_softrst;
    logic [31:0] d;
    wr(9'h040, 32'h0000_0001);
    rd(9'h050, d); chk("R6 soft reset clears", d, 0);
    rd(9'h010, d); chk("R9 ch0 kept", d, 32'h0000_0002);
    rd(9'h040, d); chk("R6 bit0 reads 0", d, 0);
    chk("R6 ch1 drops", 32'(chan_irq), 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(9'h020, 32'hFFFF_FFFF);
    wr(9'h004, 32'hFFFF_FFFF);
    rd(9'h010, d); chk("R7 en untouched", d, 32'h0000_0002);
    wr(9'h008, 32'hFFFF_FFFF);
    rd(9'h008, d); chk("R8 unmapped read", d, 0);
    rd(9'h011, d); chk("R8 misaligned read", d, 0);
    wr(9'h090, 32'hFFFF_FFFF);
    rd(9'h090, d); chk("R8 channel 2 read", d, 0);
    rd(9'h010, d); chk("R8 ch0 en untouched", d, 32'h0000_0002);
    rd(9'h050, d); chk("R8 ch1 en untouched", d, 0);
    @(negedge clk);
    chk("R8 outputs untouched", 32'(chan_irq), 0);
  endtask

  task automatic t_rerst;
    logic [31:0] d;
    wr(9'h010, 32'hFFFF_FFFF);
    drive(32'h0000_0100);
    chk("R1 pre-reset up", 32'(chan_irq), 32'b01);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 outputs cleared", 32'(chan_irq), 0);
    rd(9'h010, d); chk("R1 en cleared", d, 0);
    @(negedge clk);
    chk("R1 stays low", 32'(chan_irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_level();
    t_vector();
    drive(0);
    t_indep();
    t_softrst();
    drive(0);
    t_ignored();
    t_rerst();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule